// File: doc/BRIEF.md
# Prescaled Cycle Counter Peripheral

This block is a small register-mapped timing peripheral. Its programmable prescaler is a 32-bit down-counter. Whenever that down-counter sits at zero, it reloads from a 32-bit reload register on the next clock and advances a 32-bit cycle counter by one. Software can slow the cycle counter to any integer fraction of the system clock in this way. Software can also read and overwrite the live prescale count, which lets it re-phase the prescaler without waiting for it to reach zero.

Two further counters run freely at one tick per second and one hundred ticks per second. They are derived from the system clock by internal dividers whose ratios come from a clock-frequency parameter. The block also has a two-bit output register that drives indicator lines and a two-bit read-only view of two input lines.

Software reaches every register over a plain synchronous bus. The bus carries a word address, a write strobe and write data, and read data is returned combinationally from the current address.

Top module: `prescaled_cycle_counter`

## Requirements
- R1: While `rst_n` is low, every counter, the reload register and the indicator register are cleared to zero.
- R2: The word address selects a register. Address 0 is the indicator register, 2 the input lines, 4 the 1 Hz counter, 5 the 100 Hz counter, 6 the cycle counter, 8 the reload value and 9 the live prescale count. Any other address reads as zero.
- R3: When the prescale count is non-zero and not being written, it drops by one on each clock. When it is zero, it takes the reload value on the next clock.
- R4: The cycle counter rises by one on every clock in which the prescale count is zero. With a reload value of zero, it therefore rises on every clock.
- R5: A write to any counter appears on the following clock edge and replaces the increment or decrement that would have happened on that edge.
- R6: The 1 Hz counter rises once every `CLK_HZ` clocks and the 100 Hz counter once every `CLK_HZ/100` clocks. The first rise of each comes after exactly that many clocks following reset release.
- R7: Writing the 1 Hz or 100 Hz counter changes only its value. The divider phase that times its ticks is not disturbed.
- R8: Every counter wraps from 0xFFFFFFFF to 0 and raises no flag.
- R9: `led_o` equals bits [1:0] of the last value written to address 0. That register reads back with bits [31:2] zero.
- R10: Address 2 returns the live `btn_i` level in bits [1:0], with bits [31:2] zero. Writes to address 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address of the register accessed |
| we | input | 1 | Write strobe, sampled at the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address (combinational) |
| led_o | output | 2 | Indicator outputs |
| btn_i | input | 2 | Input lines read back through address 2 |

## Verification
The assertions assume that `addr`, `we` and `wdata` are synchronous to `clk` and hold known values whenever reset is released. They also assume at most one register is written per clock. The stimulus meets these assumptions by changing every input only at the falling edge and by issuing one write per cycle. The stimulus keeps an edge count from reset release. This count places each divider tick exactly, so it can predict tick-counter values around writes. It also confirms that a write lands on the same edge as a tick without shifting later ticks.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int IO_W   = 2;

    localparam logic [ADDR_W-1:0] SEL_LED  = 4'd0;
    localparam logic [ADDR_W-1:0] SEL_BTN  = 4'd2;
    localparam logic [ADDR_W-1:0] SEL_SLOW = 4'd4;
    localparam logic [ADDR_W-1:0] SEL_FAST = 4'd5;
    localparam logic [ADDR_W-1:0] SEL_CYC  = 4'd6;
    localparam logic [ADDR_W-1:0] SEL_RLD  = 4'd8;
    localparam logic [ADDR_W-1:0] SEL_PS   = 4'd9;
endpackage

// File: rtl/pcc_tick_div.sv
module pcc_tick_div #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase;

    assign tick = (phase == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (tick)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    a_r6_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase == '0));
    a_r6_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/pcc_wr_counter.sv
module pcc_wr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         inc,
    output logic [W-1:0] val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            val <= '0;
        else if (wr_en)
            val <= wr_val;
        else if (inc)
            val <= val + 1'b1;
    end

    a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (val == $past(wr_val)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !inc) |=> $stable(val));
    a_r8_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && inc) |=> (val == $past(val) + 1'b1));
endmodule

// File: rtl/pcc_prescale.sv
module pcc_prescale #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_rld,
    input  logic         wr_ps,
    input  logic         wr_cyc,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] reload,
    output logic [W-1:0] ps_cnt,
    output logic [W-1:0] cyc_cnt
);
    logic at_zero;
    assign at_zero = (ps_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reload <= '0;
        else if (wr_rld)
            reload <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ps_cnt <= '0;
        else if (wr_ps)
            ps_cnt <= wdata;
        else if (at_zero)
            ps_cnt <= reload;
        else
            ps_cnt <= ps_cnt - 1'b1;
    end

    pcc_wr_counter #(.W(W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_cyc),
        .wr_val (wdata),
        .inc    (at_zero),
        .val    (cyc_cnt)
    );

    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ps && ps_cnt != '0) |=> (ps_cnt == $past(ps_cnt) - 1'b1));
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ps && ps_cnt == '0) |=> (ps_cnt == $past(reload)));
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cyc && ps_cnt == '0) |=> (cyc_cnt == $past(cyc_cnt) + 1'b1));
    a_r4_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cyc && ps_cnt != '0) |=> $stable(cyc_cnt));
endmodule

// File: rtl/prescaled_cycle_counter.sv
module prescaled_cycle_counter
    import pcc_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [IO_W-1:0]   led_o,
    input  logic [IO_W-1:0]   btn_i
);
    localparam int NTICK = 2;
    localparam int RATE_SLOW = 1;
    localparam int RATE_FAST = 100;

    logic [DATA_W-1:0] tick_val [NTICK];
    logic [DATA_W-1:0] reload, ps_cnt, cyc_cnt;
    logic [IO_W-1:0]   led_q;

    genvar g;
    generate
        for (g = 0; g < NTICK; g++) begin : g_tick
            localparam int RATE = (g == 0) ? RATE_SLOW : RATE_FAST;
            localparam logic [ADDR_W-1:0] SEL = (g == 0) ? SEL_SLOW : SEL_FAST;
            logic tick;
            pcc_tick_div #(.DIV(CLK_HZ / RATE)) u_div (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick)
            );
            pcc_wr_counter #(.W(DATA_W)) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (we && addr == SEL),
                .wr_val (wdata),
                .inc    (tick),
                .val    (tick_val[g])
            );
        end
    endgenerate

    pcc_prescale #(.W(DATA_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_rld  (we && addr == SEL_RLD),
        .wr_ps   (we && addr == SEL_PS),
        .wr_cyc  (we && addr == SEL_CYC),
        .wdata   (wdata),
        .reload  (reload),
        .ps_cnt  (ps_cnt),
        .cyc_cnt (cyc_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            led_q <= '0;
        else if (we && addr == SEL_LED)
            led_q <= wdata[IO_W-1:0];
    end

    assign led_o = led_q;

    always_comb begin
        rdata = '0;
        case (addr)
            SEL_LED:  rdata = {{(DATA_W-IO_W){1'b0}}, led_q};
            SEL_BTN:  rdata = {{(DATA_W-IO_W){1'b0}}, btn_i};
            SEL_SLOW: rdata = tick_val[0];
            SEL_FAST: rdata = tick_val[1];
            SEL_CYC:  rdata = cyc_cnt;
            SEL_RLD:  rdata = reload;
            SEL_PS:   rdata = ps_cnt;
            default:  rdata = '0;
        endcase
    end

    a_r9_led_update: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == SEL_LED) |=> (led_o == $past(wdata[IO_W-1:0])));
    a_r9_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == SEL_LED) |=> $stable(led_o));
endmodule

// File: tb/prescaled_cycle_counter_test.sv
module prescaled_cycle_counter_test;
    localparam int CLK_HZ = 1000;
    localparam int DSLOW = CLK_HZ;
    localparam int DFAST = CLK_HZ / 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  led_o;
    logic [1:0]  btn_i = 2'b00;

    int total = 0;
    int bad = 0;
    int ecount = 0;

    prescaled_cycle_counter #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we),
        .wdata(wdata), .rdata(rdata), .led_o(led_o), .btn_i(btn_i)
    );

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) ecount <= ecount + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int e);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
        e = ecount;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            check("R1/R2 reset read", v, 32'h0);
        end
        check("R1 led reset", {30'h0, led_o}, 32'h0);
    endtask

    task automatic t_ticks;
        logic [31:0] v;
        edges(25);
        rd(4'd5, v); check("R6 fast count", v, 32'd2);
        rd(4'd4, v); check("R6 slow none yet", v, 32'd0);
        rd(4'd6, v); check("R4 reload zero every clock", v, 32'd25);
        rd(4'd9, v); check("R3 prescale idle zero", v, 32'd0);
    endtask

    task automatic t_override;
        logic [31:0] v;
        int e;
        wr(4'd6, 32'd5, e);
        rd(4'd6, v); check("R5 write beats increment", v, 32'd5);
        edges(1);
        rd(4'd6, v); check("R4 increment after write", v, 32'd6);
        wr(4'd6, 32'hFFFF_FFFF, e);
        rd(4'd6, v); check("R8 cycle at max", v, 32'hFFFF_FFFF);
        edges(1);
        rd(4'd6, v); check("R8 cycle wraps", v, 32'd0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        int e;
        wr(4'd8, 32'd3, e);
        wr(4'd9, 32'd3, e);
        wr(4'd6, 32'd100, e);
        rd(4'd8, v); check("R2 reload readback", v, 32'd3);
        rd(4'd9, v); check("R3 decrement", v, 32'd2);
        rd(4'd6, v); check("R4 held value", v, 32'd100);
        edges(2);
        rd(4'd9, v); check("R3 reach zero", v, 32'd0);
        rd(4'd6, v); check("R4 no advance while nonzero", v, 32'd100);
        edges(1);
        rd(4'd9, v); check("R3 reload", v, 32'd3);
        rd(4'd6, v); check("R4 advance on zero", v, 32'd101);
        edges(4);
        rd(4'd9, v); check("R3 periodic reload", v, 32'd3);
        rd(4'd6, v); check("R4 period reload+1", v, 32'd102);
        wr(4'd8, 32'd0, e);
    endtask

    task automatic t_phase;
        logic [31:0] v;
        int e;
        wr(4'd5, 32'h100, e);
        edges(37);
        rd(4'd5, v);
        check("R7 fast phase kept", v, 32'h100 + 32'(ecount / DFAST - e / DFAST));
    endtask

    task automatic t_slow_wrap;
        logic [31:0] v;
        int e, target;
        wr(4'd4, 32'hFFFF_FFFF, e);
        target = (e / DSLOW + 1) * DSLOW;
        edges(target - 1 - ecount);
        rd(4'd4, v); check("R7 slow held until tick", v, 32'hFFFF_FFFF);
        edges(1);
        rd(4'd4, v); check("R8/R6 slow wraps on tick", v, 32'd0);
    endtask

    task automatic t_io;
        logic [31:0] v;
        int e;
        wr(4'd0, 32'hFFFF_FFFE, e);
        check("R9 led drive", {30'h0, led_o}, 32'd2);
        rd(4'd0, v); check("R9 led readback", v, 32'd2);
        btn_i = 2'b01;
        rd(4'd2, v); check("R10 button read", v, 32'd1);
        wr(4'd2, 32'hFFFF_FFFF, e);
        rd(4'd2, v); check("R10 write ignored", v, 32'd1);
        btn_i = 2'b10;
        rd(4'd2, v); check("R10 button live", v, 32'd2);
        rd(4'd3, v); check("R2 unmapped zero", v, 32'd0);
        check("R10 write leaves led", {30'h0, led_o}, 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ticks();
        t_override();
        t_prescale();
        t_phase();
        t_slow_wrap();
        t_io();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule